// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a memory device. It walks the standard sixteen-state TMS-driven controller, holds a three-bit instruction, and steers one of three data paths to the serial output: a one-bit bypass stage, a 32-bit identification word, or an external boundary-scan chain that is reached only through a serial return input. It brings out decoded controls for that chain, a strobe that forces the data pins of the device to high impedance, and a flag that shows the identification path is selected.

There is no separate test reset pin. An active-low power-on reset puts the controller in its reset state. Five TCK cycles with TMS high bring it back to that state from anywhere. The reset state loads the identification instruction. The identification word is built from four parameter fields and a fixed low-order 1. During the identification instruction, TDI shifts in at its top end, so a scan longer than 32 bits returns the data that was shifted in.

Top module: `scan_tap`

## Requirements
- R1: After power-on reset, and before any TCK edge, the controller is in its reset state: `id_sel`=1, `force_hiz`=0, `bsr_sel`=0 and `tdo_en`=0.
- R2: The state register follows the standard sixteen-state graph on rising TCK edges. In the reset state, the instruction is reloaded with code 001 (identification) at the falling TCK edge.
- R3: Instruction codes decode as follows. 000 and 010 select the sampling path with the pins forced to high impedance (`bsr_sel`=1, `force_hiz`=1). 100 selects the sampling path with the pins left alone (`bsr_sel`=1, `force_hiz`=0). 001 selects identification (`id_sel`=1). 011, 101, 110 and 111 select bypass (all three flags 0).
- R4: In Capture-IR, the instruction shifter loads binary 001. Shifting moves the bits toward bit 0: bit 0 goes out first and TDI enters at bit 2. A three-bit IR scan therefore returns 1,0,0.
- R5: A newly shifted instruction changes the decoded outputs only at the falling TCK edge in Update-IR. Until then, including in Exit1-IR, the previous instruction stays in force.
- R6: With bypass selected, Capture-DR clears the bypass stage to 0. Each Shift-DR cycle loads TDI into the stage, so TDO shows the data delayed by one cycle. The stage keeps the last bit shifted in across Pause-DR and comes out again when shifting resumes.
- R7: The identification word is, from bit 31 to bit 0: the revision field (bits 31:28), the configuration field (27:18), the vendor field (17:12), the manufacturer field (11:1), and a constant 1 in bit 0. It loads in Capture-DR and shifts out LSB first.
- R8: During identification shifting, TDI enters at bit 31, so bit k of the data shifted in appears on TDO 32 shift cycles after it was applied.
- R9: TDO and `tdo_en` change only on falling TCK edges. `tdo_en` is 1 only while the controller is in Shift-IR or Shift-DR.
- R10: Five consecutive TCK cycles with TMS high return the controller to reset from any state, which restores the identification instruction.
- R11: While the sampling path is selected, `bsr_capture` is 1 only in Capture-DR, `bsr_shift` is 1 only in Shift-DR, and TDO in Shift-DR carries `bsr_so`. With any other instruction, both strobes stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| bsr_so | input | 1 | Serial return from the external boundary-scan chain |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | Output enable for TDO |
| force_hiz | output | 1 | Forces the device data pins to high impedance |
| bsr_sel | output | 1 | Boundary-scan path selected |
| bsr_capture | output | 1 | Boundary-scan parallel capture strobe |
| bsr_shift | output | 1 | Boundary-scan shift enable |
| id_sel | output | 1 | Identification path selected |

## Verification
The bench loads each of the eight instruction codes and checks the decoded flags, so duplicated codes are shown to land on the same path while neighbouring codes land on different ones. Identification scans of 32 and 64 bits separate the captured word from the data fed in through TDI. A bypass scan with a pause in the middle separates the cleared capture value from the held last bit. Runs of five TMS ones, started from inside the DR shift state and the IR shift state, show that reset is reached from deep in either branch.

// File: rtl/scan_tap_pkg.sv
`timescale 1ns/1ps
package scan_tap_pkg;

  localparam int IR_W  = 3;
  localparam int REV_W = 4;
  localparam int CFG_W = 10;
  localparam int VND_W = 6;
  localparam int MFR_W = 11;
  localparam int ID_W  = REV_W + CFG_W + VND_W + MFR_W + 1;

  typedef enum logic [3:0] {
    S_RESET, S_IDLE,
    S_DR_SEL, S_DR_CAP, S_DR_SHIFT, S_DR_EXIT1, S_DR_PAUSE, S_DR_EXIT2, S_DR_UPD,
    S_IR_SEL, S_IR_CAP, S_IR_SHIFT, S_IR_EXIT1, S_IR_PAUSE, S_IR_EXIT2, S_IR_UPD
  } tap_state_e;

  typedef enum logic [1:0] {
    OP_SAMPLE_HIZ, OP_IDCODE, OP_SAMPLE, OP_BYPASS
  } tap_op_e;

  localparam logic [IR_W-1:0] IDCODE_CODE = 3'b001;

  function automatic tap_state_e tap_next(tap_state_e s, logic m);
    tap_state_e n;
    case (s)
      S_RESET:    n = m ? S_RESET    : S_IDLE;
      S_IDLE:     n = m ? S_DR_SEL   : S_IDLE;
      S_DR_SEL:   n = m ? S_IR_SEL   : S_DR_CAP;
      S_DR_CAP:   n = m ? S_DR_EXIT1 : S_DR_SHIFT;
      S_DR_SHIFT: n = m ? S_DR_EXIT1 : S_DR_SHIFT;
      S_DR_EXIT1: n = m ? S_DR_UPD   : S_DR_PAUSE;
      S_DR_PAUSE: n = m ? S_DR_EXIT2 : S_DR_PAUSE;
      S_DR_EXIT2: n = m ? S_DR_UPD   : S_DR_SHIFT;
      S_DR_UPD:   n = m ? S_DR_SEL   : S_IDLE;
      S_IR_SEL:   n = m ? S_RESET    : S_IR_CAP;
      S_IR_CAP:   n = m ? S_IR_EXIT1 : S_IR_SHIFT;
      S_IR_SHIFT: n = m ? S_IR_EXIT1 : S_IR_SHIFT;
      S_IR_EXIT1: n = m ? S_IR_UPD   : S_IR_PAUSE;
      S_IR_PAUSE: n = m ? S_IR_EXIT2 : S_IR_PAUSE;
      S_IR_EXIT2: n = m ? S_IR_UPD   : S_IR_SHIFT;
      default:    n = m ? S_DR_SEL   : S_IDLE;
    endcase
    return n;
  endfunction

  function automatic tap_op_e op_decode(logic [IR_W-1:0] code);
    tap_op_e k;
    case (code)
      3'b000, 3'b010: k = OP_SAMPLE_HIZ;
      3'b001:         k = OP_IDCODE;
      3'b100:         k = OP_SAMPLE;
      default:        k = OP_BYPASS;
    endcase
    return k;
  endfunction

  function automatic logic is_shift(tap_state_e s);
    return (s == S_DR_SHIFT) || (s == S_IR_SHIFT);
  endfunction

  function automatic logic [ID_W-1:0] id_pack(logic [REV_W-1:0] rev, logic [CFG_W-1:0] cfg,
                                              logic [VND_W-1:0] vnd, logic [MFR_W-1:0] mfr);
    return {rev, cfg, vnd, mfr, 1'b1};
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
`timescale 1ns/1ps
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tms,
  output tap_state_e state_q
);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state_q <= S_RESET;
    else        state_q <= tap_next(state_q, tms);
  end

  // run length of TMS ones, saturating at five, watched by the assertions
  logic [2:0] ones_q;
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)              ones_q <= 3'd0;
    else if (!tms)           ones_q <= 3'd0;
    else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
  end

  a_r10_five_ones_reset: assert property (@(posedge tck) disable iff (!por_n)
    (ones_q == 3'd5) |-> (state_q == S_RESET));

  a_r2_idle_hold: assert property (@(posedge tck) disable iff (!por_n)
    (state_q == S_IDLE && !tms) |=> (state_q == S_IDLE));

  a_r2_reset_hold: assert property (@(posedge tck) disable iff (!por_n)
    (state_q == S_RESET && tms) |=> (state_q == S_RESET));

endmodule

// File: rtl/scan_tap_ir.sv
`timescale 1ns/1ps
module scan_tap_ir
  import scan_tap_pkg::*;
#(
  parameter logic [IR_W-1:0] RESET_CODE = IDCODE_CODE
) (
  input  logic            tck,
  input  logic            por_n,
  input  logic            tdi,
  input  tap_state_e      state_q,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_so
);

  localparam logic [IR_W-1:0] CAP_PATTERN = {{(IR_W-2){1'b0}}, 2'b01};

  logic cap_ev, shift_ev, upd_ev, rst_ev;
  assign cap_ev   = (state_q == S_IR_CAP);
  assign shift_ev = (state_q == S_IR_SHIFT);
  assign upd_ev   = (state_q == S_IR_UPD);
  assign rst_ev   = (state_q == S_RESET);

  logic [IR_W-1:0] sr_q;
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)        sr_q <= CAP_PATTERN;
    else if (cap_ev)   sr_q <= CAP_PATTERN;
    else if (shift_ev) sr_q <= {tdi, sr_q[IR_W-1:1]};
  end
  assign ir_so = sr_q[0];

  // the held instruction changes on the falling edge, as the standard does
  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n)      ir_q <= RESET_CODE;
    else if (rst_ev) ir_q <= RESET_CODE;
    else if (upd_ev) ir_q <= sr_q;
  end

  a_r4_capture_pattern: assert property (@(posedge tck) disable iff (!por_n)
    cap_ev |=> (sr_q[1:0] == 2'b01));

  a_r5_ir_hold: assert property (@(negedge tck) disable iff (!por_n)
    (!upd_ev && !rst_ev) |=> $stable(ir_q));

  a_r2_reset_code: assert property (@(negedge tck) disable iff (!por_n)
    rst_ev |=> (ir_q == RESET_CODE));

endmodule

// File: rtl/scan_tap_dr.sv
`timescale 1ns/1ps
module scan_tap_dr
  import scan_tap_pkg::*;
#(
  parameter logic [ID_W-1:0] ID_VALUE = {{(ID_W-1){1'b0}}, 1'b1}
) (
  input  logic       tck,
  input  logic       por_n,
  input  logic       tdi,
  input  tap_state_e state_q,
  input  tap_op_e    op,
  output logic       byp_so,
  output logic       id_so
);

  logic cap_ev, shift_ev, byp_on, id_on;
  assign cap_ev   = (state_q == S_DR_CAP);
  assign shift_ev = (state_q == S_DR_SHIFT);
  assign byp_on   = (op == OP_BYPASS);
  assign id_on    = (op == OP_IDCODE);

  logic byp_q;
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                  byp_q <= 1'b0;
    else if (cap_ev && byp_on)   byp_q <= 1'b0;
    else if (shift_ev && byp_on) byp_q <= tdi;
  end
  assign byp_so = byp_q;

  logic [ID_W-1:0] id_q;
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                 id_q <= ID_VALUE;
    else if (cap_ev && id_on)   id_q <= ID_VALUE;
    else if (shift_ev && id_on) id_q <= {tdi, id_q[ID_W-1:1]};
  end
  assign id_so = id_q[0];

  a_r6_bypass_clear: assert property (@(posedge tck) disable iff (!por_n)
    (cap_ev && byp_on) |=> (byp_q == 1'b0));

  a_r7_id_load: assert property (@(posedge tck) disable iff (!por_n)
    (cap_ev && id_on) |=> (id_q == ID_VALUE && id_q[0]));

  a_r8_id_tdi_entry: assert property (@(posedge tck) disable iff (!por_n)
    (shift_ev && id_on) |=> (id_q[ID_W-1] == $past(tdi)));

endmodule

// File: rtl/scan_tap.sv
`timescale 1ns/1ps
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter logic [REV_W-1:0] ID_REV = 4'h2,
  parameter logic [CFG_W-1:0] ID_CFG = 10'h14B,
  parameter logic [VND_W-1:0] ID_VND = 6'h15,
  parameter logic [MFR_W-1:0] ID_MFR = 11'h2B5
) (
  input  logic tck,
  input  logic por_n,
  input  logic tms,
  input  logic tdi,
  input  logic bsr_so,
  output logic tdo,
  output logic tdo_en,
  output logic force_hiz,
  output logic bsr_sel,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic id_sel
);

  localparam logic [ID_W-1:0] ID_VALUE = id_pack(ID_REV, ID_CFG, ID_VND, ID_MFR);

  tap_state_e      state_q;
  logic [IR_W-1:0] ir_q;
  logic            ir_so, byp_so, id_so;
  tap_op_e         op;

  scan_tap_fsm u_fsm (
    .tck(tck), .por_n(por_n), .tms(tms), .state_q(state_q)
  );

  scan_tap_ir #(.RESET_CODE(IDCODE_CODE)) u_ir (
    .tck(tck), .por_n(por_n), .tdi(tdi), .state_q(state_q), .ir_q(ir_q), .ir_so(ir_so)
  );

  assign op = op_decode(ir_q);

  scan_tap_dr #(.ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .por_n(por_n), .tdi(tdi), .state_q(state_q), .op(op),
    .byp_so(byp_so), .id_so(id_so)
  );

  assign force_hiz   = (op == OP_SAMPLE_HIZ);
  assign bsr_sel     = (op == OP_SAMPLE_HIZ) || (op == OP_SAMPLE);
  assign id_sel      = (op == OP_IDCODE);
  assign bsr_capture = bsr_sel && (state_q == S_DR_CAP);
  assign bsr_shift   = bsr_sel && (state_q == S_DR_SHIFT);

  logic tdo_d;
  always_comb begin
    if (state_q == S_IR_SHIFT) tdo_d = ir_so;
    else begin
      case (op)
        OP_IDCODE: tdo_d = id_so;
        OP_BYPASS: tdo_d = byp_so;
        default:   tdo_d = bsr_so;
      endcase
    end
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_en <= is_shift(state_q);
    end
  end

  a_r9_enable_in_shift: assert property (@(posedge tck) disable iff (!por_n)
    tdo_en == is_shift(state_q));

  a_r3_hiz_on_bsr_path: assert property (@(posedge tck) disable iff (!por_n)
    force_hiz |-> (bsr_sel && !id_sel));

  a_r11_strobes_exclusive: assert property (@(posedge tck) disable iff (!por_n)
    $onehot0({bsr_capture, bsr_shift}));

endmodule

// File: tb/scan_tap_tb_top.sv
`timescale 1ns/1ps
module scan_tap_tb_top;

  localparam logic [31:0] ID_EXP = {4'h2, 10'h14B, 6'h15, 11'h2B5, 1'b1};

  logic tck = 1'b0, por_n = 1'b0, tms = 1'b1, tdi = 1'b1, bsr_so = 1'b0;
  logic tdo, tdo_en, force_hiz, bsr_sel, bsr_capture, bsr_shift, id_sel;

  always #2 tck = ~tck;

  scan_tap #(.ID_REV(4'h2), .ID_CFG(10'h14B), .ID_VND(6'h15), .ID_MFR(11'h2B5)) dut_i (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .bsr_so(bsr_so),
    .tdo(tdo), .tdo_en(tdo_en), .force_hiz(force_hiz), .bsr_sel(bsr_sel),
    .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .id_sel(id_sel)
  );

  typedef struct {
    string       tag;
    logic [63:0] v;
  } item_t;

  item_t exp_q[$];
  item_t act_q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : monitor
    item_t a, e;
    forever begin
      wait (act_q.size() != 0);
      a = act_q.pop_front();
      e = exp_q.pop_front();
      check(e.tag, a.v, e.v);
    end
  end

  // inputs change just after a falling edge; outputs are read there too
  task automatic tick(logic m, logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  // from Run-Test-Idle: scan n bits through IR or DR, back to Run-Test-Idle
  task automatic scan(bit ir, int n, logic [63:0] din, string tag, logic [63:0] exp);
    item_t e, a;
    logic [63:0] got = '0;
    e.tag = tag; e.v = exp;
    exp_q.push_back(e);
    tick(1, 1);
    if (ir) tick(1, 1);
    tick(0, 1);
    tick(0, 1);
    for (int i = 0; i < n; i++) begin
      got[i] = tdo;
      tick(i == n - 1, din[i]);
    end
    a.tag = tag; a.v = got;
    act_q.push_back(a);
    tick(1, 1);
    tick(0, 1);
  endtask

  task automatic load_ir(logic [2:0] code);
    scan(1, 3, {61'b0, code}, "R4 ir capture", 64'd1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (3) @(negedge tck);
    #1 por_n = 1'b1;
    // R1 reset state
    check("R1 tdo_en", tdo_en, 0);
    check("R1 id_sel", id_sel, 1);
    check("R1 force_hiz", force_hiz, 0);
    check("R1 bsr_sel", bsr_sel, 0);
    tick(0, 1);
    check("R9 tdo_en idle", tdo_en, 0);

    // R7 identification word, R8 TDI feeds through
    scan(0, 32, 64'h0, "R7 id word", {32'h0, ID_EXP});
    scan(0, 64, {32'h0, 32'hC3A5_0F96}, "R8 id passthrough", {32'hC3A5_0F96, ID_EXP});

    // R3 decode of every code
    for (int c = 0; c < 8; c++) begin
      logic [2:0] code = 3'(c);
      bit hz = (code == 3'b000) || (code == 3'b010);
      load_ir(code);
      check($sformatf("R3 force_hiz code %0d", c), force_hiz, hz);
      check($sformatf("R3 bsr_sel code %0d", c), bsr_sel, hz || (code == 3'b100));
      check($sformatf("R3 id_sel code %0d", c), id_sel, code == 3'b001);
    end

    // R5 instruction takes effect only at Update-IR (bypass held now)
    tick(1, 1); tick(1, 1); tick(0, 1); tick(0, 1);
    tick(0, 1); tick(0, 0); tick(1, 0);
    check("R5 exit1 keeps old", id_sel, 0);
    tick(0, 1);
    check("R5 pause keeps old", id_sel, 0);
    tick(1, 1); tick(1, 1);
    check("R5 update applies", id_sel, 1);
    tick(0, 1);

    // R6 bypass path
    load_ir(3'b011);
    scan(0, 8, 64'hB6, "R6 bypass delay", 64'h6C);
    tick(1, 1); tick(0, 1);
    check("R11 no capture strobe in bypass", bsr_capture, 0);
    tick(0, 1);
    check("R6 captured zero", tdo, 0);
    check("R9 tdo_en shift", tdo_en, 1);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    check("R9 tdo holds past rising edge", tdo, 0);
    @(negedge tck); #1;
    check("R6 shifted one", tdo, 1);
    tick(0, 0);
    check("R6 shifted zero", tdo, 0);
    tick(1, 1);
    tick(0, 1);
    check("R9 tdo_en pause", tdo_en, 0);
    tick(1, 1); tick(0, 0);
    check("R6 held across pause", tdo, 1);
    tick(1, 1); tick(1, 1); tick(0, 1);

    // R11 sampling path controls
    load_ir(3'b100);
    check("R3 sample keeps pins", force_hiz, 0);
    tick(1, 1); tick(0, 1);
    check("R11 capture strobe", {bsr_capture, bsr_shift}, 2'b10);
    tick(0, 1);
    check("R11 shift strobe", {bsr_capture, bsr_shift}, 2'b01);
    bsr_so = 1'b1; tick(0, 1);
    check("R11 tdo follows chain 1", tdo, 1);
    bsr_so = 1'b0; tick(0, 1);
    check("R11 tdo follows chain 0", tdo, 0);
    tick(1, 1); tick(1, 1); tick(0, 1);
    load_ir(3'b010);
    check("R3 sample-z forces hiz", force_hiz, 1);

    // R10 five ones from Shift-DR and from Shift-IR
    tick(1, 1); tick(0, 1); tick(0, 1);
    for (int k = 0; k < 5; k++) tick(1, 1);
    check("R10 from shift-dr id_sel", id_sel, 1);
    check("R2 reset clears hiz", force_hiz, 0);
    tick(0, 1);
    load_ir(3'b111);
    tick(1, 1); tick(1, 1); tick(0, 1); tick(0, 0);
    for (int k = 0; k < 5; k++) tick(1, 1);
    check("R10 from shift-ir id_sel", id_sel, 1);
    check("R10 tdo_en off", tdo_en, 0);

    wait (act_q.size() == 0);
    #1;
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule